// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor and a slower word-wide memory. It keeps recently used words in a cache with two ways per set. A processor request is a word address and, for a store, a data word. The low address bits pick a set, and the high bits form a tag. That tag is compared against both ways of the chosen set. On a hit the request is served from the cache. On a miss one way is picked as the victim. If the victim is valid and modified, it is written back to memory first, and then the missing word is fetched into that way.

Lines hold a single word. Stores use the write-back policy: a store that hits changes only the cached copy and marks it modified. Memory is updated only when a modified line is evicted. Each way of each set carries one recency bit, where 1 means "eligible for eviction". All recency bits reset to 1.

The processor request channel is valid/ready, with these back-pressure rules:
- The processor holds its request fields steady while `cpu_req_valid` is high and `cpu_req_ready` is low.
- A request is taken on a clock edge where both are high.
- After a request is taken, `cpu_req_ready` stays low until the response has been produced.
- The response is a one-cycle `cpu_rsp_valid` pulse. It cannot be stalled.

The memory channel is a request/acknowledge handshake:
- The controller holds `mem_req` and its fields steady until `mem_ack` is seen.
- `mem_ack` is high for one cycle. For a read, `mem_rdata` is valid in that cycle.

Top module: `cache2way_ctrl`

## Requirements
- R1: An address splits into a tag (the upper TAG_W bits) and a set index (the remaining low bits). Two addresses with the same index and different tags can be resident at once, one per way, and both then hit.
- R2: A read hit returns the stored word with `cpu_rsp_valid` one clock after the request is taken, and it makes no memory request.
- R3: After reset, every way of every set is invalid with recency bit 1. `cpu_req_ready` is high, and `cpu_rsp_valid` and `mem_req` are low. The first access to any set is a miss.
- R4: A hit on a way clears that way's recency bit and sets the other way's bit, so the other way becomes the next victim in that set.
- R5: The victim on a miss is chosen in this order: an invalid way first, with way 0 when both are invalid; otherwise the way whose recency bit is 1; way 0 when both bits are 1. The two bits of a set are never both 0.
- R6: A read miss reads memory at the request address, installs that tag and word in the victim way, marks the way the most recent, and returns the fetched word.
- R7: A write hit updates only the cached word, marks it modified, and makes no memory request. The response carries the written word.
- R8: A write miss fetches the word from memory, installs the written word in the victim way, and marks it modified. The response carries the written word.
- R9: A victim that is valid and modified is written to memory at its own tag and index, with its data, before the fill read is issued. A clean or invalid victim causes no memory write.
- R10: `cpu_req_ready` is low from the cycle after a request is taken until its response. While `mem_req` is high and not acknowledged, its address, direction and data stay stable.
- R11: Each taken request produces exactly one single-cycle `cpu_rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address (tag, then index) |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DATA_W | Loaded word, or the stored word for a store |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory transfer done (one cycle) |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
The bench builds the controller with an 8-bit address, a 4-bit tag and 12-bit words, which gives 16 sets. That geometry keeps only 256 distinct addresses, so random traffic over four tags per set returns to the same sets often. Under that traffic, two-way conflicts, recency flips, evictions of modified lines and back-to-back write-back then fill sequences all come up many times. The memory side is answered after a random delay, which exercises the hold rules of the memory handshake.

// File: rtl/cache2way_pkg.sv
package cache2way_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL
  } ctrl_st_t;
endpackage

// File: rtl/cache2way_way.sv
// One way of the cache: tag/data storage plus per-set valid, dirty and
// recency bits. All writes go to the same set index that is being read.
module cache2way_way #(
  parameter int TAG_W   = 6,
  parameter int INDEX_W = 9,
  parameter int DATA_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic               rd_used,
  input  logic               line_we,
  input  logic               data_we,
  input  logic [TAG_W-1:0]   line_tag,
  input  logic [DATA_W-1:0]  line_data,
  input  logic               line_dirty,
  input  logic               use_we,
  input  logic               use_val
);
  localparam int SETS = 1 << INDEX_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [SETS-1:0]   used_q;

  assign rd_tag   = tag_mem[idx];
  assign rd_data  = data_mem[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_used  = used_q[idx];

  always_ff @(posedge clk) begin
    if (line_we) begin
      tag_mem[idx]  <= line_tag;
      data_mem[idx] <= line_data;
    end else if (data_we) begin
      data_mem[idx] <= line_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      used_q  <= '1;
    end else begin
      if (line_we) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= line_dirty;
      end else if (data_we) begin
        dirty_q[idx] <= 1'b1;
      end
      if (use_we) used_q[idx] <= use_val;
    end
  end
endmodule

// File: rtl/cache2way_pick.sv
// Victim choice: invalid way first (way 0 preferred), then the way whose
// recency bit is set, way 0 when both are set.
module cache2way_pick (
  input  logic v0,
  input  logic v1,
  input  logic u0,
  input  logic u1,
  output logic victim
);
  always_comb begin
    if (!v0)      victim = 1'b0;
    else if (!v1) victim = 1'b1;
    else if (u0)  victim = 1'b0;
    else if (u1)  victim = 1'b1;
    else          victim = 1'b0;
  end
endmodule

// File: rtl/cache2way_ctrl.sv
module cache2way_ctrl
  import cache2way_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int INDEX_W = ADDR_W - TAG_W;
  localparam int WAYS    = 2;

  ctrl_st_t           st;
  logic               req_we_q;
  logic [TAG_W-1:0]   req_tag_q;
  logic [INDEX_W-1:0] req_idx_q;
  logic [DATA_W-1:0]  req_wdata_q;
  logic               vict_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  logic [TAG_W-1:0]   w_tag   [WAYS];
  logic [DATA_W-1:0]  w_data  [WAYS];
  logic [WAYS-1:0]    w_valid, w_dirty, w_used, w_hit;
  logic [WAYS-1:0]    line_we, data_we, use_val;
  logic               use_we;
  logic [DATA_W-1:0]  line_data;
  logic               hit, hit_way, pick_way, upd_way, look_w;

  assign look_w    = (st == ST_LOOK);
  assign hit       = |w_hit;
  assign hit_way   = w_hit[1];
  assign line_data = req_we_q ? req_wdata_q : mem_rdata;
  assign upd_way   = look_w ? hit_way : vict_q;

  always_comb begin
    line_we = '0;
    data_we = '0;
    use_we  = 1'b0;
    if (look_w && hit) begin
      use_we           = 1'b1;
      data_we[hit_way] = req_we_q;
    end
    if (st == ST_FILL && mem_ack) begin
      use_we          = 1'b1;
      line_we[vict_q] = 1'b1;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign w_hit[g]   = w_valid[g] && (w_tag[g] == req_tag_q);
    assign use_val[g] = (upd_way != 1'(g));
    cache2way_way #(
      .TAG_W(TAG_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)
    ) u_way (
      .clk(clk), .rst_n(rst_n), .idx(req_idx_q),
      .rd_tag(w_tag[g]), .rd_data(w_data[g]), .rd_valid(w_valid[g]),
      .rd_dirty(w_dirty[g]), .rd_used(w_used[g]),
      .line_we(line_we[g]), .data_we(data_we[g]), .line_tag(req_tag_q),
      .line_data(line_data), .line_dirty(req_we_q),
      .use_we(use_we), .use_val(use_val[g])
    );
  end

  cache2way_pick u_pick (
    .v0(w_valid[0]), .v1(w_valid[1]), .u0(w_used[0]), .u1(w_used[1]),
    .victim(pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_tag_q   <= '0;
      req_idx_q   <= '0;
      req_wdata_q <= '0;
      vict_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (cpu_req_valid) begin
          req_we_q    <= cpu_req_we;
          req_tag_q   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
          req_idx_q   <= cpu_req_addr[INDEX_W-1:0];
          req_wdata_q <= cpu_req_wdata;
          st          <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= req_we_q ? req_wdata_q : w_data[hit_way];
          st          <= ST_IDLE;
        end else begin
          vict_q <= pick_way;
          st     <= (w_valid[pick_way] && w_dirty[pick_way]) ? ST_WB : ST_FILL;
        end
        ST_WB: if (mem_ack) st <= ST_FILL;
        ST_FILL: if (mem_ack) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= line_data;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (st == ST_IDLE);
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;
  assign mem_req       = (st == ST_WB) || (st == ST_FILL);
  assign mem_we        = (st == ST_WB);
  assign mem_addr      = (st == ST_WB) ? {w_tag[vict_q], req_idx_q}
                                       : {req_tag_q, req_idx_q};
  assign mem_wdata     = w_data[vict_q];
endmodule

// File: rtl/cache2way_chk.sv
module cache2way_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              in_lookup,
  input logic              lookup_hit,
  input logic [1:0]        use_pair
);
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lookup && lookup_hit) |=> (!mem_req && cpu_rsp_valid));

  a_r5_use_pair: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup |-> (use_pair != 2'b00));

  a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
endmodule

bind cache2way_ctrl cache2way_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .in_lookup(look_w),
  .lookup_hit(hit), .use_pair(w_used)
);

// File: tb/cache2way_ctrl_bench.sv
module cache2way_ctrl_bench;
  localparam int AW   = 8;
  localparam int TW   = 4;
  localparam int DW   = 12;
  localparam int IW   = AW - TW;
  localparam int SETS = 1 << IW;
  localparam int NADR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic          cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cache2way_ctrl #(.ADDR_W(AW), .TAG_W(TW), .DATA_W(DW)) u_cache2way_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid),
    .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem_model [NADR];
  logic [DW-1:0] golden    [NADR];
  int            n_mrd = 0;
  int            n_mwr = 0;
  logic [AW-1:0] last_wb_addr = '0;
  logic [DW-1:0] last_wb_data = '0;
  int            dly = 0;

  // reference cache state
  logic [TW-1:0] rtag [SETS][2];
  logic          rval [SETS][2];
  logic          rdty [SETS][2];
  logic          ruse [SETS][2];

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'((a * 37 + 5) ^ (a << 4));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: random latency, one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      dly = $urandom % 4;
    end else if (mem_req) begin
      if (dly == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_model[mem_addr];
        if (mem_we) begin
          mem_model[mem_addr] = mem_wdata;
          n_mwr++;
          last_wb_addr = mem_addr;
          last_wb_data = mem_wdata;
        end else begin
          n_mrd++;
        end
      end else begin
        dly--;
      end
    end
  end

  task automatic model_step(input bit we, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, output bit hit,
                            output bit wb, output logic [AW-1:0] wb_a,
                            output logic [DW-1:0] wb_d);
    int s;
    int w;
    logic [TW-1:0] t;
    s = int'(a[IW-1:0]);
    t = a[AW-1 -: TW];
    wb = 1'b0; wb_a = '0; wb_d = '0;
    if (rval[s][0] && rtag[s][0] == t) begin hit = 1; w = 0; end
    else if (rval[s][1] && rtag[s][1] == t) begin hit = 1; w = 1; end
    else begin
      hit = 0;
      if (!rval[s][0]) w = 0;
      else if (!rval[s][1]) w = 1;
      else if (ruse[s][0]) w = 0;
      else if (ruse[s][1]) w = 1;
      else w = 0;
      if (rval[s][w] && rdty[s][w]) begin
        wb = 1'b1;
        wb_a = {rtag[s][w], a[IW-1:0]};
        wb_d = golden[wb_a];
      end
      rval[s][w] = 1; rtag[s][w] = t; rdty[s][w] = 0;
    end
    if (we) begin rdty[s][w] = 1; golden[a] = d; end
    ruse[s][w] = 0; ruse[s][1-w] = 1;
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string lbl);
    bit hit, wb;
    logic [AW-1:0] wb_a;
    logic [DW-1:0] wb_d, exp_d;
    int rd0, wr0, lat;
    string rq;
    model_step(we, a, d, hit, wb, wb_a, wb_d);
    exp_d = we ? d : golden[a];
    rd0 = n_mrd; wr0 = n_mwr;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 0;
    while (!cpu_rsp_valid) begin
      if (cpu_req_ready) check(0, "R10", "ready while busy", 1, 0);
      @(negedge clk);
      lat++;
    end
    if (lbl != "") rq = lbl;
    else if (hit) rq = we ? "R7" : "R2";
    else rq = we ? "R8" : "R5";
    check((n_mrd - rd0) == (hit ? 0 : 1), rq, "fill reads", n_mrd - rd0, hit ? 0 : 1);
    check((n_mwr - wr0) == (wb ? 1 : 0), "R9", "write-backs", n_mwr - wr0, wb ? 1 : 0);
    if (wb) begin
      check(last_wb_addr == wb_a, "R9", "write-back address", last_wb_addr, wb_a);
      check(last_wb_data == wb_d, "R9", "write-back data", last_wb_data, wb_d);
    end
    check(cpu_rsp_rdata == exp_d, we ? "R8" : (hit ? "R2" : "R6"),
          "response data", cpu_rsp_rdata, exp_d);
    if (hit) check(lat == 1, "R2", "hit latency", lat, 1);
    @(negedge clk);
    check(cpu_rsp_valid == 1'b0, "R11", "response pulse width", cpu_rsp_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < NADR; a++) begin
      mem_model[a] = init_word(a);
      golden[a]    = init_word(a);
    end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) begin
        rval[s][w] = 0; rdty[s][w] = 0; ruse[s][w] = 1; rtag[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R3", "ready after reset", cpu_req_ready, 1);
    check(cpu_rsp_valid == 1'b0, "R3", "rsp after reset", cpu_rsp_valid, 0);
    check(mem_req == 1'b0, "R3", "mem_req after reset", mem_req, 0);

    // directed: set 3, tags 1,2,3
    access(0, {4'd1, 4'd3}, '0, "R3");   // first access misses, way 0
    access(0, {4'd2, 4'd3}, '0, "R5");   // invalid way 1 taken
    access(0, {4'd1, 4'd3}, '0, "R1");   // both resident
    access(0, {4'd2, 4'd3}, '0, "R1");
    access(0, {4'd1, 4'd3}, '0, "R4");   // way 1 now the victim
    access(0, {4'd3, 4'd3}, '0, "R5");   // evicts tag 2
    access(0, {4'd1, 4'd3}, '0, "R4");   // tag 1 kept
    access(1, {4'd1, 4'd3}, 12'h5A5, "R7");
    access(1, {4'd4, 4'd3}, 12'hC3C, "R8"); // write miss evicts tag 3
    access(0, {4'd5, 4'd3}, '0, "R9");   // dirty tag 1 written back
    access(0, {4'd6, 4'd3}, '0, "R9");   // dirty tag 4 written back
    access(0, {4'd1, 4'd3}, '0, "R6");

    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] a;
      a = {TW'($urandom % 4), IW'($urandom)};
      access(($urandom % 2) == 1, a, DW'($urandom), "");
    end

    for (int a = 0; a < NADR; a++) begin
      int s;
      bit held;
      s = a % SETS;
      held = 0;
      for (int w = 0; w < 2; w++)
        if (rval[s][w] && rdty[s][w] && rtag[s][w] == TW'(a >> IW)) held = 1;
      if (!held) check(mem_model[a] == golden[a], "R9", "memory contents",
                       mem_model[a], golden[a]);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule